// File: doc/BRIEF.md
# Stepper Step-Pulse Rate Generator

This block produces the step and direction signals for one stepper or servo axis. A host loads a set of staged settings through a simple write port: a signed travel length, a base rate, a top rate, ramp-up and ramp-down rates, and a rate divider. A start command copies the staged values into working registers and begins the move. The block then emits exactly as many step pulses as the magnitude of the travel, all at the base rate. The direction output follows the sign of the travel. The staged copy stays writable during a move, so the next move can be prepared while the current one runs. A setting that does not change between moves need not be written again.

The step rate comes from a phase accumulator. Every clock it adds the base rate, and a pulse is due each time the sum reaches `(divider + 1) * 2^SPD_W`. The excess is kept, so the step frequency equals `rate * f_clk / ((divider + 1) * 2^SPD_W)`. Busy and done report progress. A stop input ends a move early, after the pulse in progress has finished, and the count of pulses not yet sent stays readable. A start that asks for an accelerated move is checked against the rate settings. Ramp generation itself is the job of a neighbouring stage. That stage takes the effective ramp-down rate from this block.

There is no data stream at this block's edge. The write port is a plain strobe with no back-pressure: the host may write in any cycle, and a write always takes effect at the next clock edge. Start and stop are single-cycle control pulses.

Top module: `step_rate_gen`

## Requirements
- R1: A write with `wr_en` high loads the staged register chosen by `wr_sel`, taking the low bits of `wr_data`. The codes are 0 travel, 1 base rate, 2 top rate, 3 ramp-up rate, 4 ramp-down rate and 5 divider. Working values change only on an accepted start. A staged value that was not rewritten is reused by later moves, and writes made during a move do not alter that move.
- R2: Count clock edges from the edge that samples an accepted start, calling that edge 0. The n-th step pulse then rises on edge `ceil(n * L / F)`, where `L = (D + 1) * 2^SPD_W`. Here F is the working base rate and D is the working divider.
- R3: Each step pulse stays high for exactly `HI_CLKS` clocks.
- R4: The number of pulses equals the magnitude of the two's-complement travel, including the most negative value. `dir` is 1 for a negative travel and 0 otherwise. It is set on edge 0 and stays stable for the whole move. `remaining` equals the magnitude after edge 0 and drops by one on each pulse edge.
- R5: A staged base rate of 0 is used as 1, and a staged divider below 2 is used as 2.
- R6: After an accepted start, `dec_rate` shows the staged ramp-down rate. If that rate is 0, it shows the staged ramp-up rate instead.
- R7: A start with `accel` high is rejected when the top rate is not greater than the effective base rate. A rejected start raises `cfg_err`, begins no move and leaves `remaining` unchanged. The next accepted start clears `cfg_err`.
- R8: A start while busy is ignored, and the move in progress keeps its timing and count.
- R9: A start with zero travel keeps `busy` low and raises `done` for exactly one cycle, right after edge 0.
- R10: Once `stop` is sampled during a move, no new pulse begins. The move ends on the first edge at which no pulse is high. `done` is raised and `remaining` holds the unsent count.
- R11: `busy` is high from edge 0 until the move ends. On a full move it ends on edge `ceil(N * L / F) + HI_CLKS + 1`, where N is the pulse count. On that same edge `busy` falls and `done` rises for one cycle.
- R12: After reset, `step`, `dir`, `busy`, `done` and `cfg_err` are 0 and `remaining` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Staged register write strobe |
| wr_sel | input | 3 | Staged register select |
| wr_data | input | POS_W | Write data, low bits used for narrow fields |
| start | input | 1 | Start a move from the staged settings |
| accel | input | 1 | Start requests an accelerated move (validated) |
| stop | input | 1 | Abort the running move |
| step | output | 1 | Step pulse |
| dir | output | 1 | Direction, 1 = negative travel |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle end-of-move flag |
| cfg_err | output | 1 | Last accelerated start was rejected |
| remaining | output | POS_W | Pulses not yet sent |
| dec_rate | output | SPD_W | Effective ramp-down rate for the ramp stage |

## Verification
A corrupted accumulator remainder shifts a pulse edge by a clock within a few periods. Every pulse edge is compared against the closed-form ceiling formula on every clock. A wrong pulse counter shows at once as a step in `remaining` that does not match the number of pulse edges. It then shows again as a `done` that comes too early or too late. Faults in the staging and commit path show on the first cycle after start, either as a wrong `dec_rate` or `dir`, or as a first pulse edge out of place. A stop that is mishandled shows as a pulse that should not exist, or as `remaining` moving after the abort.

// File: rtl/step_pkg.sv
package step_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;

  localparam logic [2:0] SEL_TRAVEL = 3'd0;
  localparam logic [2:0] SEL_BASE   = 3'd1;
  localparam logic [2:0] SEL_TOP    = 3'd2;
  localparam logic [2:0] SEL_UP     = 3'd3;
  localparam logic [2:0] SEL_DOWN   = 3'd4;
  localparam logic [2:0] SEL_DIV    = 3'd5;
endpackage

// File: rtl/step_stage.sv
module step_stage #(
  parameter int SPD_W = 16,
  parameter int MUL_W = 12,
  parameter int POS_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [POS_W-1:0] wr_data,
  input  logic             commit,
  output logic [SPD_W-1:0] w_base,
  output logic [MUL_W-1:0] w_div,
  output logic [SPD_W-1:0] w_down,
  output logic [POS_W-1:0] s_mag,
  output logic             s_neg,
  output logic             s_top_bad
);
  import step_pkg::*;

  logic [POS_W-1:0] s_travel;
  logic [SPD_W-1:0] s_base, s_top, s_up, s_down;
  logic [MUL_W-1:0] s_div;
  logic [SPD_W-1:0] base_eff;
  logic [MUL_W-1:0] div_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_travel <= '0;
      s_base   <= '0;
      s_top    <= '0;
      s_up     <= '0;
      s_down   <= '0;
      s_div    <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_TRAVEL: s_travel <= wr_data;
        SEL_BASE:   s_base   <= wr_data[SPD_W-1:0];
        SEL_TOP:    s_top    <= wr_data[SPD_W-1:0];
        SEL_UP:     s_up     <= wr_data[SPD_W-1:0];
        SEL_DOWN:   s_down   <= wr_data[SPD_W-1:0];
        SEL_DIV:    s_div    <= wr_data[MUL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    base_eff  = (s_base == '0) ? SPD_W'(1) : s_base;
    div_eff   = (s_div < MUL_W'(2)) ? MUL_W'(2) : s_div;
    s_neg     = s_travel[POS_W-1];
    s_mag     = s_neg ? (~s_travel + POS_W'(1)) : s_travel;
    s_top_bad = (s_top <= base_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_base <= SPD_W'(1);
      w_div  <= MUL_W'(2);
      w_down <= '0;
    end else if (commit) begin
      w_base <= base_eff;
      w_div  <= div_eff;
      w_down <= (s_down == '0) ? s_up : s_down;
    end
  end

  // R5: the working copy never carries an illegal rate or divider
  a_r5_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (w_base != '0) && (w_div >= MUL_W'(2)));

  // R1: working values move only on a commit
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(w_base) && $stable(w_div) && $stable(w_down));
endmodule

// File: rtl/step_phase.sv
module step_phase #(
  parameter int SPD_W = 16,
  parameter int MUL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SPD_W-1:0] rate,
  input  logic [MUL_W-1:0] div,
  output logic             tick_raw
);
  localparam int ACC_W = SPD_W + MUL_W + 1;

  logic [ACC_W-1:0] acc, sum, lim;

  always_comb begin
    lim      = (ACC_W'(div) + ACC_W'(1)) << SPD_W;
    sum      = acc + ACC_W'(rate);
    tick_raw = en && (sum >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= tick_raw ? (sum - lim) : sum;
  end

  // R2: the kept remainder is always below one period
  a_r2_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc < lim);

  // R2: a divider of at least 2 keeps ticks three or more clocks apart
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_raw |=> !tick_raw);
endmodule

// File: rtl/step_seq.sv
module step_seq #(
  parameter int POS_W   = 28,
  parameter int HI_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             accel,
  input  logic             stop,
  input  logic [POS_W-1:0] s_mag,
  input  logic             s_neg,
  input  logic             s_top_bad,
  input  logic             tick_raw,
  output logic             accept,
  output logic             running,
  output logic             step,
  output logic             dir,
  output logic             done,
  output logic             cfg_err,
  output logic [POS_W-1:0] remaining
);
  import step_pkg::*;

  localparam int HI_W = $clog2(HI_CLKS + 1);

  run_state_e      state;
  logic [HI_W-1:0] hi_cnt;
  logic            stop_pend;
  logic            tick;
  logic            finish;

  always_comb begin
    running = (state == ST_RUN);
    accept  = start && !running && !(accel && s_top_bad);
    step    = (hi_cnt != '0);
    tick    = running && tick_raw && (remaining != '0) && !stop && !stop_pend;
    finish  = running && (hi_cnt == '0) &&
              ((remaining == '0) || stop || stop_pend);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hi_cnt    <= '0;
      stop_pend <= 1'b0;
      dir       <= 1'b0;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
      remaining <= '0;
    end else begin
      done <= 1'b0;
      if (!running) begin
        if (start && accel && s_top_bad) begin
          cfg_err <= 1'b1;
        end else if (accept) begin
          cfg_err   <= 1'b0;
          dir       <= s_neg;
          remaining <= s_mag;
          stop_pend <= 1'b0;
          if (s_mag == '0) done  <= 1'b1;
          else             state <= ST_RUN;
        end
      end else begin
        if (stop) stop_pend <= 1'b1;
        if (tick) begin
          remaining <= remaining - POS_W'(1);
          hi_cnt    <= HI_W'(HI_CLKS);
        end else if (hi_cnt != '0) begin
          hi_cnt <= hi_cnt - HI_W'(1);
        end
        if (finish) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  // R3: a new pulse never starts while one is still high
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> hi_cnt == '0);

  // R4: direction holds through a move
  a_r4_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) |-> $stable(dir));

  // R8: a start during a move never reloads the count
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    running && start |=> remaining <= $past(remaining));

  // R9: a zero-length move ends at once without going busy
  a_r9_zero_move: assert property (@(posedge clk) disable iff (!rst_n)
    accept && s_mag == '0 |=> done && !running);

  // R11: done lasts a single cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  // R10: after an abort the count is frozen until the next start
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start |=> $stable(remaining));
endmodule

// File: rtl/step_rate_gen.sv
module step_rate_gen #(
  parameter int SPD_W   = 16,
  parameter int MUL_W   = 12,
  parameter int POS_W   = 28,
  parameter int HI_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [POS_W-1:0] wr_data,
  input  logic             start,
  input  logic             accel,
  input  logic             stop,
  output logic             step,
  output logic             dir,
  output logic             busy,
  output logic             done,
  output logic             cfg_err,
  output logic [POS_W-1:0] remaining,
  output logic [SPD_W-1:0] dec_rate
);
  logic [SPD_W-1:0] w_base;
  logic [MUL_W-1:0] w_div;
  logic [POS_W-1:0] s_mag;
  logic             s_neg, s_top_bad;
  logic             accept, tick_raw;

  step_stage #(.SPD_W(SPD_W), .MUL_W(MUL_W), .POS_W(POS_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .commit(accept), .w_base(w_base), .w_div(w_div),
    .w_down(dec_rate), .s_mag(s_mag), .s_neg(s_neg), .s_top_bad(s_top_bad)
  );

  step_phase #(.SPD_W(SPD_W), .MUL_W(MUL_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(busy),
    .rate(w_base), .div(w_div), .tick_raw(tick_raw)
  );

  step_seq #(.POS_W(POS_W), .HI_CLKS(HI_CLKS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .accel(accel), .stop(stop),
    .s_mag(s_mag), .s_neg(s_neg), .s_top_bad(s_top_bad),
    .tick_raw(tick_raw), .accept(accept), .running(busy), .step(step),
    .dir(dir), .done(done), .cfg_err(cfg_err), .remaining(remaining)
  );

  // R12: quiet outputs right after reset
  a_r12_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> !busy && !step && !done && !cfg_err && remaining == '0);
endmodule

// File: tb/step_rate_gen_tb_top.sv
module step_rate_gen_tb_top;
  localparam int SPD_W = 8;
  localparam int MUL_W = 4;
  localparam int POS_W = 12;
  localparam int HI    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [POS_W-1:0] wr_data = '0;
  logic start = 1'b0, accel = 1'b0, stop = 1'b0;
  logic step, dir, busy, done, cfg_err;
  logic [POS_W-1:0] remaining;
  logic [SPD_W-1:0] dec_rate;

  int n_chk = 0;
  int n_bad = 0;
  int cur_up = 0, cur_down = 0, cur_base = 0, cur_div = 0;

  always #4 clk = ~clk;

  step_rate_gen #(.SPD_W(SPD_W), .MUL_W(MUL_W), .POS_W(POS_W), .HI_CLKS(HI)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .accel(accel), .stop(stop), .step(step), .dir(dir),
    .busy(busy), .done(done), .cfg_err(cfg_err), .remaining(remaining),
    .dec_rate(dec_rate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = POS_W'(val);
    @(negedge clk);
    wr_en = 1'b0;
    if (sel == 1) cur_base = val;
    if (sel == 3) cur_up = val;
    if (sel == 4) cur_down = val;
    if (sel == 5) cur_div = val;
  endtask

  // drives start on the next edge (edge 0); returns at the negedge after it
  task automatic kick(input bit acc);
    @(negedge clk);
    start = 1'b1; accel = acc;
    @(negedge clk);
    start = 1'b0; accel = 1'b0;
  endtask

  task automatic run_move(input int pos, input bit rates, input int base,
                          input int dv, input bit inject);
    int fe, de, lim, n, kn, last;
    if (rates) begin
      wr(1, base); wr(5, dv);
    end
    wr(0, pos);
    fe  = (cur_base == 0) ? 1 : cur_base;
    de  = (cur_div < 2) ? 2 : cur_div;
    lim = (de + 1) << SPD_W;
    n   = (pos < 0) ? -pos : pos;
    kn  = (n * lim + fe - 1) / fe;
    last = kn + HI + 2;
    kick(1'b0);
    chk("R6 dec_rate", int'(dec_rate), (cur_down == 0) ? cur_up : cur_down);
    for (int c = 0; c <= last; c++) begin
      int nt, es, ek;
      if (c > 0) @(negedge clk);
      nt = (c * fe) / lim;
      if (nt > n) nt = n;
      ek = (nt * lim + fe - 1) / fe;
      es = (nt >= 1 && (c - ek) < HI) ? 1 : 0;
      chk("R2 R3 step", int'(step), es);
      chk("R11 busy", int'(busy), (c <= kn + HI) ? 1 : 0);
      chk("R11 done", int'(done), (c == kn + HI + 1) ? 1 : 0);
      chk("R4 remaining", int'(remaining), n - nt);
      chk("R4 dir", int'(dir), (pos < 0) ? 1 : 0);
      if (inject && c == 5) begin
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = POS_W'(base + 77);
        start = 1'b1;
      end else if (inject && c == 6) begin
        wr_en = 1'b0; start = 1'b0;  // R8: start during a move ignored
        cur_base = base + 77;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int idx;
    int divs[3];
    int bases[3];
    divs  = '{2, 7, 15};
    bases = '{255, 100, 13};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 step", int'(step), 0);
    chk("R12 busy", int'(busy), 0);
    chk("R12 done", int'(done), 0);
    chk("R12 cfg_err", int'(cfg_err), 0);
    chk("R12 dir", int'(dir), 0);
    chk("R12 remaining", int'(remaining), 0);

    // R1 R2 R4 R6 R11 sweep over divider, base rate and travel sign
    idx = 0;
    foreach (divs[i]) begin
      foreach (bases[j]) begin
        wr(3, 20 + idx);
        wr(4, (idx % 2 == 1) ? 0 : 40 + idx);
        run_move(((idx % 2) == 0 ? 1 : -1) * (3 + idx % 3), 1'b1, bases[j], divs[i], 1'b0);
        idx++;
      end
    end

    // R1 staged rates reused without rewrite
    run_move(-4, 1'b0, 0, 0, 1'b0);
    // R8 start plus staged write during a move
    run_move(6, 1'b1, 50, 3, 1'b1);
    // R5 clamps
    run_move(2, 1'b1, 0, 2, 1'b0);
    run_move(3, 1'b1, 200, 0, 1'b0);

    // R10 stop on most negative travel: pulses at edges 4 and 7 for base 255 div 2
    wr(1, 255); wr(5, 2); wr(0, -2048);
    kick(1'b0);
    chk("R4 most negative remaining", int'(remaining), 2048);
    chk("R4 most negative dir", int'(dir), 1);
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == 4) stop = 1'b1;
      if (c == 5) stop = 1'b0;
      chk("R10 step", int'(step), (c == 4 || c == 5) ? 1 : 0);
      chk("R10 done", int'(done), (c == 7) ? 1 : 0);
      chk("R10 busy", int'(busy), (c < 7) ? 1 : 0);
      if (c >= 4) chk("R10 remaining", int'(remaining), 2047);
    end

    // R7 rejected accelerated start
    wr(1, 100); wr(2, 50); wr(0, 5);
    kick(1'b1);
    chk("R7 cfg_err", int'(cfg_err), 1);
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      chk("R7 busy", int'(busy), 0);
      chk("R7 step", int'(step), 0);
      chk("R7 remaining", int'(remaining), 2047);
    end
    wr(2, 200);
    kick(1'b1);
    chk("R7 cfg_err cleared", int'(cfg_err), 0);
    chk("R7 accepted busy", int'(busy), 1);
    chk("R7 accepted remaining", int'(remaining), 5);
    wait (done == 1'b1);
    @(negedge clk);

    // R9 zero travel
    wr(0, 0);
    kick(1'b0);
    chk("R9 done", int'(done), 1);
    chk("R9 busy", int'(busy), 0);
    @(negedge clk);
    chk("R9 done once", int'(done), 0);
    chk("R9 busy stays low", int'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule